// File: doc/BRIEF.md
# Neighbour-Lane Operand Router

This block sits in front of a 64-lane vector ALU. In one pass it replaces each lane's first source operand with a value taken from another lane. A 9-bit pattern code chooses the source lane, and the block also works out whether each lane may write its destination. The lanes form 4 rows of 16. Each row is split into 4 banks of 4 lanes. The block supports a fixed set of patterns:

- a crossbar inside each group of four lanes;
- single-lane shifts and rotates across the whole wave;
- shifts and rotates by 1 to 15 lanes inside each row;
- mirrors over a row or over a half-row;
- two broadcasts that carry a row's last lane into later rows.

A source lane is invalid when it lies outside the wave or row, or when the execution mask disables it. A bound-control bit decides what happens to a lane whose source is invalid. Either the lane stays silent, or it takes zero as its operand and still writes. Three masks gate the write: the execution mask, a per-row mask and a per-bank mask. A scan written as a short run of these patterns therefore needs no extra data-movement instructions. All three outputs are registered once, so every result appears one clock after its inputs.

Top module: `lane_operand_router`

## Requirements
- R1: While reset is asserted, the operand vector, the write enables and the zero flags are all zero.
- R2: The outputs for inputs presented before a rising clock edge appear at that edge and stay unchanged until the next edge.
- R3: Codes 0x000 to 0x0FF select the quad crossbar. Lane 4q+p reads lane 4q+code[2p+1:2p].
- R4: Codes 0x101 to 0x10F are row shift left by n = code[3:0]: row position p reads p+n, and the source is invalid when p+n > 15. Codes 0x111 to 0x11F are row shift right: p reads p-n, and the source is invalid when p < n. Codes 0x121 to 0x12F are row rotate right: p reads (p-n) mod 16.
- R5: The wave codes each move by one lane. 0x130 is shift left: lane i reads i+1, and lane 63 is invalid. 0x134 is rotate left: lane i reads (i+1) mod 64. 0x138 is shift right: lane i reads i-1, and lane 0 is invalid. 0x13C is rotate right: lane i reads (i-1) mod 64.
- R6: Code 0x140 mirrors each row, so position p reads 15-p. Code 0x141 mirrors each 8-lane half-row, so position p reads 7-p within its half.
- R7: Code 0x142 makes every lane of row r+1 read lane 16r+15, and lanes of row 0 have an invalid source. Code 0x143 makes every lane of rows 2 and 3 read lane 31, and lanes of rows 0 and 1 have an invalid source.
- R8: Any code not listed in R3 to R7 routes every lane from itself. This includes shift amount 0.
- R9: A source is invalid if it is out of range or if its execution-mask bit is 0. A lane whose source is invalid receives the operand 0. A lane with a valid source receives that lane's value, whether or not the lane itself is enabled.
- R10: When bound control is 0, an enabled lane whose source is invalid has write enable 0 and zero flag 0. When bound control is 1, such a lane has write enable 1 and zero flag 1. The zero flag is never 1 for a lane whose source is valid.
- R11: Lane i is enabled only if three bits are all set: exec bit i, row-mask bit i/16 and bank-mask bit i[3:2]. A disabled lane has write enable 0 and zero flag 0.
- R12: Seven passes compute an inclusive prefix sum over the 64 lanes, with each pass adding the routed operand to the other ALU input:
  - row shifts right by 1, 2 and 3 with bound control 1;
  - row shift right by 4 with bank mask 0xE;
  - row shift right by 8 with bank mask 0xC;
  - the lane-15 broadcast with row mask 0xA;
  - the lane-31 broadcast with row mask 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| src_vec | input | LANES*DATA_W | Source operand, lane i at bits [i*DATA_W +: DATA_W] |
| exec_mask | input | LANES | Execution mask, one bit per lane |
| pat_ctrl | input | 9 | Pattern code |
| row_mask | input | LANES/ROW_LANES | Row enable, one bit per row |
| bank_mask | input | ROW_LANES/BANK_LANES | Bank enable, one bit per bank |
| bound_ctrl | input | 1 | 1: an invalid source supplies zero and the lane writes |
| opnd_vec | output | LANES*DATA_W | Routed operand vector |
| lane_wr_en | output | LANES | Per-lane destination write enable |
| lane_zero | output | LANES | Per-lane flag: the operand was forced to zero |

## Verification
The operand vector, the write enables and the zero flags all come from a single register bank. Each of them is due exactly one rising edge after its inputs are applied. The bench drives each vector on a falling edge. One time unit later it confirms that the outputs still show the previous vector, which shows there is no path from input to output without a register. At the next falling edge it compares all three outputs against a behavioural lane model. The prefix-sum run reuses the same one-edge timing for each of its seven passes, feeding each registered result into the next pass.

// File: rtl/lane_route_pkg.sv
package lane_route_pkg;

  localparam int CTRL_W = 9;

  typedef enum logic [3:0] {
    PF_IDENT,
    PF_QUAD,
    PF_ROW_SHL,
    PF_ROW_SHR,
    PF_ROW_ROR,
    PF_WAVE_SHL,
    PF_WAVE_ROL,
    PF_WAVE_SHR,
    PF_WAVE_ROR,
    PF_MIRROR,
    PF_HMIRROR,
    PF_BCAST_ROW,
    PF_BCAST_HALF
  } pat_fam_e;

  typedef struct packed {
    pat_fam_e    fam;
    logic [3:0]  amt;
    logic [7:0]  qsel;
  } pat_cmd_t;

endpackage

// File: rtl/lane_pat_decode.sv
module lane_pat_decode
  import lane_route_pkg::*;
(
  input  logic [CTRL_W-1:0] pat_ctrl,
  output pat_cmd_t          cmd
);

  always_comb begin
    cmd.fam  = PF_IDENT;
    cmd.amt  = pat_ctrl[3:0];
    cmd.qsel = pat_ctrl[7:0];
    if (!pat_ctrl[8]) begin
      cmd.fam = PF_QUAD;
    end else begin
      unique case (pat_ctrl[7:4])
        4'h0: cmd.fam = (pat_ctrl[3:0] != 4'd0) ? PF_ROW_SHL : PF_IDENT;
        4'h1: cmd.fam = (pat_ctrl[3:0] != 4'd0) ? PF_ROW_SHR : PF_IDENT;
        4'h2: cmd.fam = (pat_ctrl[3:0] != 4'd0) ? PF_ROW_ROR : PF_IDENT;
        4'h3: begin
          unique case (pat_ctrl[3:0])
            4'h0:    cmd.fam = PF_WAVE_SHL;
            4'h4:    cmd.fam = PF_WAVE_ROL;
            4'h8:    cmd.fam = PF_WAVE_SHR;
            4'hC:    cmd.fam = PF_WAVE_ROR;
            default: cmd.fam = PF_IDENT;
          endcase
        end
        4'h4: begin
          unique case (pat_ctrl[3:0])
            4'h0:    cmd.fam = PF_MIRROR;
            4'h1:    cmd.fam = PF_HMIRROR;
            4'h2:    cmd.fam = PF_BCAST_ROW;
            4'h3:    cmd.fam = PF_BCAST_HALF;
            default: cmd.fam = PF_IDENT;
          endcase
        end
        default: cmd.fam = PF_IDENT;
      endcase
    end
  end

endmodule

// File: rtl/lane_src_sel.sv
module lane_src_sel
  import lane_route_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int LANE_ID   = 0
) (
  input  pat_cmd_t                   cmd,
  output logic [$clog2(LANES)-1:0]   src_idx,
  output logic                       in_range
);

  localparam int IDX_W = $clog2(LANES);
  localparam int QUAD  = 4;
  localparam int POS   = LANE_ID % ROW_LANES;
  localparam int BASE  = LANE_ID - POS;
  localparam int HALF  = ROW_LANES / 2;
  localparam int QBASE = LANE_ID - (LANE_ID % QUAD);
  localparam int QPOS  = LANE_ID % QUAD;

  int   j;
  int   amt;
  logic ok;

  always_comb begin
    amt = int'(cmd.amt);
    j   = LANE_ID;
    ok  = 1'b1;
    unique case (cmd.fam)
      PF_QUAD:       j = QBASE + int'(cmd.qsel[2*QPOS +: 2]);
      PF_ROW_SHL: begin
        ok = (POS + amt) < ROW_LANES;
        j  = LANE_ID + amt;
      end
      PF_ROW_SHR: begin
        ok = POS >= amt;
        j  = LANE_ID - amt;
      end
      PF_ROW_ROR:    j = BASE + ((POS - amt + ROW_LANES) % ROW_LANES);
      PF_WAVE_SHL: begin
        ok = LANE_ID < (LANES - 1);
        j  = LANE_ID + 1;
      end
      PF_WAVE_ROL:   j = (LANE_ID + 1) % LANES;
      PF_WAVE_SHR: begin
        ok = LANE_ID > 0;
        j  = LANE_ID - 1;
      end
      PF_WAVE_ROR:   j = (LANE_ID + LANES - 1) % LANES;
      PF_MIRROR:     j = BASE + ROW_LANES - 1 - POS;
      PF_HMIRROR:    j = BASE + (POS / HALF) * HALF + HALF - 1 - (POS % HALF);
      PF_BCAST_ROW: begin
        ok = BASE > 0;
        j  = BASE - 1;
      end
      PF_BCAST_HALF: begin
        ok = LANE_ID >= 2 * ROW_LANES;
        j  = 2 * ROW_LANES - 1;
      end
      default:       j = LANE_ID;
    endcase
    in_range = ok;
    src_idx  = ok ? IDX_W'(j) : '0;
  end

endmodule

// File: rtl/lane_gate.sv
module lane_gate #(
  parameter int DATA_W     = 32,
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4
) (
  input  logic [LANES*DATA_W-1:0]          src_vec,
  input  logic [LANES-1:0]                 exec_mask,
  input  logic [LANES/ROW_LANES-1:0]       row_mask,
  input  logic [ROW_LANES/BANK_LANES-1:0]  bank_mask,
  input  logic                             bound_ctrl,
  input  logic [LANES*$clog2(LANES)-1:0]   src_idx_flat,
  input  logic [LANES-1:0]                 in_range,
  output logic [LANES*DATA_W-1:0]          opnd_d,
  output logic [LANES-1:0]                 wr_en_d,
  output logic [LANES-1:0]                 zero_d
);

  localparam int IDX_W = $clog2(LANES);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [IDX_W-1:0] sidx;
    logic             src_ok;
    logic             lane_en;

    assign sidx    = src_idx_flat[gi*IDX_W +: IDX_W];
    assign src_ok  = in_range[gi] & exec_mask[sidx];
    assign lane_en = exec_mask[gi] & row_mask[gi / ROW_LANES]
                   & bank_mask[(gi % ROW_LANES) / BANK_LANES];

    assign opnd_d[gi*DATA_W +: DATA_W] = src_ok ? src_vec[sidx*DATA_W +: DATA_W] : '0;
    assign wr_en_d[gi] = lane_en & (src_ok | bound_ctrl);
    assign zero_d[gi]  = lane_en & ~src_ok & bound_ctrl;
  end

endmodule

// File: rtl/lane_operand_router.sv
module lane_operand_router
  import lane_route_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LANES*DATA_W-1:0]          src_vec,
  input  logic [LANES-1:0]                 exec_mask,
  input  logic [CTRL_W-1:0]                pat_ctrl,
  input  logic [LANES/ROW_LANES-1:0]       row_mask,
  input  logic [ROW_LANES/BANK_LANES-1:0]  bank_mask,
  input  logic                             bound_ctrl,
  output logic [LANES*DATA_W-1:0]          opnd_vec,
  output logic [LANES-1:0]                 lane_wr_en,
  output logic [LANES-1:0]                 lane_zero
);

  localparam int IDX_W = $clog2(LANES);

  pat_cmd_t                    cmd;
  logic [LANES*IDX_W-1:0]      src_idx_flat;
  logic [LANES-1:0]            in_range;
  logic [LANES*DATA_W-1:0]     opnd_d;
  logic [LANES-1:0]            wr_en_d;
  logic [LANES-1:0]            zero_d;

  lane_pat_decode u_decode (
    .pat_ctrl (pat_ctrl),
    .cmd      (cmd)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_src
    lane_src_sel #(
      .LANES     (LANES),
      .ROW_LANES (ROW_LANES),
      .LANE_ID   (gi)
    ) u_sel (
      .cmd      (cmd),
      .src_idx  (src_idx_flat[gi*IDX_W +: IDX_W]),
      .in_range (in_range[gi])
    );
  end

  lane_gate #(
    .DATA_W     (DATA_W),
    .LANES      (LANES),
    .ROW_LANES  (ROW_LANES),
    .BANK_LANES (BANK_LANES)
  ) u_gate (
    .src_vec      (src_vec),
    .exec_mask    (exec_mask),
    .row_mask     (row_mask),
    .bank_mask    (bank_mask),
    .bound_ctrl   (bound_ctrl),
    .src_idx_flat (src_idx_flat),
    .in_range     (in_range),
    .opnd_d       (opnd_d),
    .wr_en_d      (wr_en_d),
    .zero_d       (zero_d)
  );

  // Output register stage: one cycle from inputs to results.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_vec   <= '0;
      lane_wr_en <= '0;
      lane_zero  <= '0;
    end else begin
      opnd_vec   <= opnd_d;
      lane_wr_en <= wr_en_d;
      lane_zero  <= zero_d;
    end
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_chk
    // R9
    zero_lane_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_zero[gi] |-> (opnd_vec[gi*DATA_W +: DATA_W] == '0));
    // R10
    zero_needs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_zero[gi] |-> $past(bound_ctrl));
    // R11
    write_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_wr_en[gi] |-> $past(exec_mask[gi]));
    // R11
    row_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(row_mask[gi / ROW_LANES]) |-> !lane_wr_en[gi]);
    // R11
    bank_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bank_mask[(gi % ROW_LANES) / BANK_LANES]) |-> !lane_wr_en[gi]);
  end

endmodule

// File: tb/lane_operand_router_test.sv
`timescale 1ns/1ps
module lane_operand_router_test;

  localparam int N  = 64;
  localparam int DW = 32;

  logic            clk;
  logic            rst_n;
  logic [N*DW-1:0] src_vec;
  logic [N-1:0]    exec_mask;
  logic [8:0]      pat_ctrl;
  logic [3:0]      row_mask;
  logic [3:0]      bank_mask;
  logic            bound_ctrl;
  logic [N*DW-1:0] opnd_vec;
  logic [N-1:0]    lane_wr_en;
  logic [N-1:0]    lane_zero;

  lane_operand_router uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_vec    (src_vec),
    .exec_mask  (exec_mask),
    .pat_ctrl   (pat_ctrl),
    .row_mask   (row_mask),
    .bank_mask  (bank_mask),
    .bound_ctrl (bound_ctrl),
    .opnd_vec   (opnd_vec),
    .lane_wr_en (lane_wr_en),
    .lane_zero  (lane_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [31:0] sa [N];
  logic [31:0] e_op [N];
  logic        e_wr [N];
  logic        e_zf [N];

  // Behavioural source-lane model: -1 means out of range.
  function automatic int ref_src(int i, logic [8:0] c);
    int r = i / 16;
    int p = i % 16;
    int n = int'(c[3:0]);
    if (!c[8]) return (i / 4) * 4 + int'(c[2*(i%4) +: 2]);
    case (c[7:4])
      4'h0: return (n == 0) ? i : ((p + n < 16) ? i + n : -1);
      4'h1: return (n == 0) ? i : ((p >= n) ? i - n : -1);
      4'h2: return r * 16 + ((p - n + 16) % 16);
      4'h3: case (c[3:0])
              4'h0: return (i < 63) ? i + 1 : -1;
              4'h4: return (i + 1) % 64;
              4'h8: return (i > 0) ? i - 1 : -1;
              4'hC: return (i + 63) % 64;
              default: return i;
            endcase
      4'h4: case (c[3:0])
              4'h0: return r * 16 + 15 - p;
              4'h1: return r * 16 + (p / 8) * 8 + 7 - (p % 8);
              4'h2: return (r > 0) ? r * 16 - 1 : -1;
              4'h3: return (r >= 2) ? 31 : -1;
              default: return i;
            endcase
      default: return i;
    endcase
  endfunction

  function automatic string fam_tag(logic [8:0] c);
    if (!c[8]) return "R3";
    case (c[7:4])
      4'h0, 4'h1, 4'h2: return (c[3:0] == 0) ? "R8" : "R4";
      4'h3: return (c[1:0] == 0) ? "R5" : "R8";
      4'h4: return (c[3:0] < 2) ? "R6" : ((c[3:0] < 4) ? "R7" : "R8");
      default: return "R8";
    endcase
  endfunction

  task automatic check_outputs(string optag);
    bit bad_op = 0, bad_wr = 0, bad_zf = 0;
    for (int i = 0; i < N; i++) begin
      if (!bad_op && opnd_vec[i*DW +: DW] !== e_op[i]) begin
        bad_op = 1;
        $display("FAIL %s,R9 lane %0d operand actual %h expected %h", optag, i,
                 opnd_vec[i*DW +: DW], e_op[i]);
      end
      if (!bad_wr && lane_wr_en[i] !== e_wr[i]) begin
        bad_wr = 1;
        $display("FAIL R10,R11 lane %0d write enable actual %b expected %b", i,
                 lane_wr_en[i], e_wr[i]);
      end
      if (!bad_zf && lane_zero[i] !== e_zf[i]) begin
        bad_zf = 1;
        $display("FAIL R10 lane %0d zero flag actual %b expected %b", i,
                 lane_zero[i], e_zf[i]);
      end
    end
    n_cmp += 3;
    n_bad += int'(bad_op) + int'(bad_wr) + int'(bad_zf);
  endtask

  // Drive one vector on a falling edge, check at the next falling edge.
  task automatic step(logic [8:0] c, logic [N-1:0] ex, logic [3:0] rm,
                      logic [3:0] bm, logic bc);
    logic [N*DW-1:0] prev_op;
    logic [N-1:0]    prev_wr;
    logic [N-1:0]    prev_zf;
    @(negedge clk);
    prev_op = opnd_vec;
    prev_wr = lane_wr_en;
    prev_zf = lane_zero;
    for (int i = 0; i < N; i++) src_vec[i*DW +: DW] = sa[i];
    exec_mask = ex; pat_ctrl = c; row_mask = rm; bank_mask = bm; bound_ctrl = bc;
    for (int i = 0; i < N; i++) begin
      int  j  = ref_src(i, c);
      bit  ok = (j >= 0) && ex[j];
      bit  en = ex[i] && rm[i/16] && bm[(i/4)%4];
      e_op[i] = ok ? sa[j] : 32'd0;
      e_wr[i] = en && (ok || bc);
      e_zf[i] = en && !ok && bc;
    end
    #1;
    // R2: no change before the clock edge
    n_cmp++;
    if (opnd_vec !== prev_op || lane_wr_en !== prev_wr || lane_zero !== prev_zf) begin
      n_bad++;
      $display("FAIL R2 outputs moved before edge: actual wr %h expected %h", lane_wr_en, prev_wr);
    end
    @(negedge clk);
    check_outputs(fam_tag(c));
  endtask

  function automatic logic [N-1:0] rnd_exec();
    return {$urandom, $urandom} | {$urandom, $urandom};
  endfunction

  task automatic fill_random();
    for (int i = 0; i < N; i++) sa[i] = $urandom;
  endtask

  logic [31:0] v0 [N];
  logic [31:0] v1 [N];

  // One prefix-sum pass: v1 = routed(src) + other, where write enabled.
  task automatic scan_pass(logic [8:0] c, logic [3:0] rm, logic [3:0] bm, logic bc,
                           bit src_is_v0, bit other_is_v0);
    for (int i = 0; i < N; i++) sa[i] = src_is_v0 ? v0[i] : v1[i];
    step(c, '1, rm, bm, bc);
    for (int i = 0; i < N; i++)
      if (lane_wr_en[i]) v1[i] = opnd_vec[i*DW +: DW] + (other_is_v0 ? v0[i] : v1[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_vec = '0; exec_mask = '0; pat_ctrl = '0;
    row_mask = '0; bank_mask = '0; bound_ctrl = 1'b0;
    fill_random();
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) src_vec[i*DW +: DW] = sa[i];
    exec_mask = '1; row_mask = '1; bank_mask = '1; pat_ctrl = 9'h100;
    @(negedge clk);
    // R1: reset state with live inputs
    n_cmp++;
    if (opnd_vec !== '0 || lane_wr_en !== '0 || lane_zero !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual wr %h zf %h expected 0 0", lane_wr_en, lane_zero);
    end
    rst_n = 1'b1;

    // R8: identity codes
    foreach (sa[k]) sa[k] = 32'h1000 + k;
    step(9'h100, '1, 4'hF, 4'hF, 1'b0);
    step(9'h110, '1, 4'hF, 4'hF, 1'b1);
    step(9'h120, '1, 4'hF, 4'hF, 1'b0);
    step(9'h131, '1, 4'hF, 4'hF, 1'b0);
    step(9'h144, '1, 4'hF, 4'hF, 1'b1);
    step(9'h1FF, '1, 4'hF, 4'hF, 1'b0);

    // R3: quad crossbar
    step(9'h0E4, '1, 4'hF, 4'hF, 1'b0);
    step(9'h01B, '1, 4'hF, 4'hF, 1'b0);
    step(9'h000, rnd_exec(), 4'hF, 4'hF, 1'b0);
    step(9'h0FF, rnd_exec(), 4'hF, 4'hF, 1'b1);
    for (int k = 0; k < 4; k++) begin
      fill_random();
      step({1'b0, 8'($urandom)}, rnd_exec(), 4'($urandom), 4'($urandom), 1'($urandom));
    end

    // R4: row shifts and rotate, every amount, both bound settings
    for (int fam = 0; fam < 3; fam++)
      for (int n = 1; n < 16; n++)
        for (int b = 0; b < 2; b++) begin
          fill_random();
          step({1'b1, 4'(fam), 4'(n)}, rnd_exec(), 4'($urandom) | 4'h9,
               4'($urandom) | 4'h6, 1'(b));
        end

    // R5, R6, R7: wave moves, mirrors, broadcasts
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 4; k++) begin
        fill_random();
        step({5'h13, 4'(k * 4)}, '1, 4'hF, 4'hF, 1'(b));
        step({5'h13, 4'(k * 4)}, rnd_exec(), 4'($urandom), 4'($urandom), 1'(b));
      end
      for (int k = 0; k < 4; k++) begin
        fill_random();
        step({5'h14, 4'(k)}, '1, 4'hF, 4'hF, 1'(b));
        step({5'h14, 4'(k)}, rnd_exec(), 4'($urandom), 4'($urandom), 1'(b));
      end
    end

    // R9, R10, R11: source lanes disabled, partial masks
    fill_random();
    step(9'h13C, 64'h5555_5555_5555_5555, 4'hF, 4'hF, 1'b1);
    step(9'h13C, 64'h5555_5555_5555_5555, 4'hF, 4'hF, 1'b0);
    step(9'h140, '1, 4'h5, 4'hA, 1'b1);
    step(9'h143, '1, 4'h0, 4'hF, 1'b1);

    // Mixed random codes
    for (int k = 0; k < 150; k++) begin
      fill_random();
      step(9'($urandom), rnd_exec(), 4'($urandom), 4'($urandom), 1'($urandom));
    end

    // R12: prefix sum across the wave
    for (int i = 0; i < N; i++) begin
      v0[i] = 32'(3 * i + 1);
      v1[i] = 32'd0;
    end
    scan_pass(9'h111, 4'hF, 4'hF, 1'b1, 1, 1);
    scan_pass(9'h112, 4'hF, 4'hF, 1'b1, 1, 0);
    scan_pass(9'h113, 4'hF, 4'hF, 1'b1, 1, 0);
    scan_pass(9'h114, 4'hF, 4'hE, 1'b0, 0, 0);
    scan_pass(9'h118, 4'hF, 4'hC, 1'b0, 0, 0);
    scan_pass(9'h142, 4'hA, 4'hF, 1'b0, 0, 0);
    scan_pass(9'h143, 4'hC, 4'hF, 1'b0, 0, 0);
    begin
      logic [31:0] acc = 32'd0;
      for (int i = 0; i < N; i++) begin
        acc += v0[i];
        n_cmp++;
        if (v1[i] !== acc) begin
          n_bad++;
          $display("FAIL R12 lane %0d prefix sum actual %0d expected %0d", i, v1[i], acc);
        end
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule